// File: doc/BRIEF.md
# Bidirectional Parity Transceiver Port

This block joins an eight-lane bidirectional bus buffer to a parity generator and checker, all in combinational logic. A direction input picks which side drives the other. When it is high, side A is forwarded to side B. When it is low, side B is forwarded to side A. A disable input, active high, turns off every driver the block owns. Each driver is given as a value output with its own drive-enable, so the wiring around the block can form the tri-state nets.

One parity line changes role with direction. While sending, the block computes parity over side A and drives it onto that line. While receiving, the block reads the line as an input and checks it against side B. The result is a status flag that is high when the check passes and low when it fails. A select input chooses even parity (low) or odd parity (high). The status flag is not driven while sending.

The block has no clock and no state. It has two operating conditions, transmit and receive, plus a disabled condition. The direction and disable inputs choose among them, and a change takes effect at once, with no transition sequence.

Top module: `ptx_transceiver`

## Requirements
- R1: With disable low and direction high (transmit), `b_oe` is 1, `a_oe` is 0 and `b_out` equals `a_in` bit for bit with no inversion.
- R2: With disable low and direction low (receive), `a_oe` is 1, `b_oe` is 0 and `a_out` equals `b_in` bit for bit.
- R3: With disable high, `a_oe`, `b_oe`, `par_oe` and `ok_oe` are all 0, whatever the other inputs are.
- R4: In transmit with `odd_sel` = 0 (even), `par_oe` is 1 and `par_out` is 1 exactly when `a_in` holds an odd number of ones.
- R5: In transmit with `odd_sel` = 1 (odd), `par_out` is 1 exactly when `a_in` holds an even number of ones.
- R6: In receive, `par_oe` is 0 and `ok_oe` is 1. With `odd_sel` = 0, `ok_out` is 1 exactly when the ones in `b_in` plus `par_in` give an even total.
- R7: In receive with `odd_sel` = 1, `ok_out` is 1 exactly when the ones in `b_in` plus `par_in` give an odd total.
- R8: In transmit, `ok_oe` is 0, so the status flag is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dir_tx | input | 1 | 1 = forward A to B and generate parity; 0 = forward B to A and check parity |
| dis | input | 1 | 1 = release every driver |
| odd_sel | input | 1 | 0 = even parity, 1 = odd parity |
| a_in | input | W | Value seen on side A |
| b_in | input | W | Value seen on side B |
| par_in | input | 1 | Value seen on the parity line |
| a_out | output | W | Value to drive on side A |
| a_oe | output | 1 | Drive-enable for side A |
| b_out | output | W | Value to drive on side B |
| b_oe | output | 1 | Drive-enable for side B |
| par_out | output | 1 | Generated parity bit |
| par_oe | output | 1 | Drive-enable for the parity line |
| ok_out | output | 1 | Check result, 1 = no error |
| ok_oe | output | 1 | Drive-enable for the check result |

## Verification
In receive, two functions act on side B at the same time: forwarding it onto side A and checking its parity with the parity line. A fault in one can hide behind the other. The sweep gives side B every byte value against both parity-line levels and both selects. For each setting it checks both `a_out` and `ok_out`, each against a value computed by the bench from a count of ones. The same sweep runs again with disable high, where every enable must drop no matter which of the two functions would otherwise be active.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

    typedef enum logic [1:0] {
        MODE_OFF = 2'd0,
        MODE_RX  = 2'd1,
        MODE_TX  = 2'd2
    } ptx_mode_e;

    typedef struct packed {
        logic a_en;
        logic b_en;
        logic par_en;
        logic ok_en;
    } ptx_drive_t;

endpackage

// File: rtl/ptx_parity_tree.sv
module ptx_parity_tree #(
    parameter int W = 8
) (
    input  logic [W-1:0] din,
    output logic         odd
);
    localparam int HALF = W / 2;

    generate
        if (W == 1) begin : g_leaf
            assign odd = din[0];
        end else begin : g_split
            logic lo_odd;
            logic hi_odd;
            ptx_parity_tree #(.W(HALF)) u_lo (
                .din (din[HALF-1:0]),
                .odd (lo_odd)
            );
            ptx_parity_tree #(.W(W - HALF)) u_hi (
                .din (din[W-1:HALF]),
                .odd (hi_odd)
            );
            assign odd = lo_odd ^ hi_odd;
        end
    endgenerate
endmodule

// File: rtl/ptx_dir_ctrl.sv
module ptx_dir_ctrl
    import ptx_pkg::*;
(
    input  logic       dir_tx,
    input  logic       dis,
    output ptx_mode_e  mode,
    output ptx_drive_t drv
);
    always_comb begin
        if (dis)         mode = MODE_OFF;
        else if (dir_tx) mode = MODE_TX;
        else             mode = MODE_RX;
    end

    always_comb begin
        drv = '0;
        unique case (mode)
            MODE_TX: begin
                drv.b_en   = 1'b1;
                drv.par_en = 1'b1;
            end
            MODE_RX: begin
                drv.a_en  = 1'b1;
                drv.ok_en = 1'b1;
            end
            default: drv = '0;
        endcase
    end
endmodule

// File: rtl/ptx_transceiver.sv
module ptx_transceiver
    import ptx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         dir_tx,
    input  logic         dis,
    input  logic         odd_sel,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         par_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    output logic         par_out,
    output logic         par_oe,
    output logic         ok_out,
    output logic         ok_oe
);
    localparam int RXW = W + 1;

    ptx_mode_e  mode;
    ptx_drive_t drv;
    logic       a_odd;
    logic       rx_odd;

    ptx_dir_ctrl u_ctrl (
        .dir_tx (dir_tx),
        .dis    (dis),
        .mode   (mode),
        .drv    (drv)
    );

    // generator over side A
    ptx_parity_tree #(.W(W)) u_gen (
        .din (a_in),
        .odd (a_odd)
    );

    // checker over side B plus the incoming parity bit
    ptx_parity_tree #(.W(RXW)) u_chk (
        .din ({par_in, b_in}),
        .odd (rx_odd)
    );

    assign b_out = a_in;
    assign a_out = b_in;

    always_comb begin
        par_out = 1'b0;
        ok_out  = 1'b0;
        unique case (mode)
            MODE_TX: par_out = a_odd ^ odd_sel;
            MODE_RX: ok_out  = rx_odd ^ ~odd_sel;
            default: ;
        endcase
    end

    assign a_oe   = drv.a_en;
    assign b_oe   = drv.b_en;
    assign par_oe = drv.par_en;
    assign ok_oe  = drv.ok_en;
endmodule

// File: rtl/ptx_transceiver_chk.sv
module ptx_transceiver_chk #(
    parameter int W = 8
) (
    input logic         dir_tx,
    input logic         dis,
    input logic         odd_sel,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic         par_in,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b_out,
    input logic         b_oe,
    input logic         par_out,
    input logic         par_oe,
    input logic         ok_out,
    input logic         ok_oe
);
    always_comb begin
        if (!dis && dir_tx)
            a_r1_fwd_ab: assert (b_oe && !a_oe && b_out == a_in);
        if (!dis && !dir_tx)
            a_r2_fwd_ba: assert (a_oe && !b_oe && a_out == b_in);
        if (dis)
            a_r3_all_off: assert ({a_oe, b_oe, par_oe, ok_oe} == 4'b0000);
        if (!dis && dir_tx)
            a_r4_r5_gen: assert (par_oe && (($countones(a_in) % 2 == 1) ^ odd_sel) == par_out);
        if (!dis && !dir_tx)
            a_r6_r7_chk: assert (ok_oe && !par_oe &&
                                 ((($countones(b_in) + par_in) % 2 == 1) ~^ odd_sel) == ok_out);
        if (dir_tx)
            a_r8_ok_off: assert (!ok_oe);
    end
endmodule

bind ptx_transceiver ptx_transceiver_chk #(.W(W)) u_chk_bind (.*);

// File: tb/ptx_transceiver_tb.sv
module ptx_transceiver_tb;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic         dir_tx, dis, odd_sel, par_in;
    logic [W-1:0] a_in, b_in;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe, par_out, par_oe, ok_out, ok_oe;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    ptx_transceiver #(.W(W)) u_dut (
        .dir_tx (dir_tx), .dis (dis), .odd_sel (odd_sel),
        .a_in (a_in), .b_in (b_in), .par_in (par_in),
        .a_out (a_out), .a_oe (a_oe), .b_out (b_out), .b_oe (b_oe),
        .par_out (par_out), .par_oe (par_oe),
        .ok_out (ok_out), .ok_oe (ok_oe)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h (dir=%0b dis=%0b odd=%0b a=%h b=%h p=%0b)",
                     req, act, exp, dir_tx, dis, odd_sel, a_in, b_in, par_in);
        end
    endtask

    function automatic int ones(input logic [W-1:0] v);
        int c = 0;
        for (int i = 0; i < W; i++) c += int'(v[i]);
        return c;
    endfunction

    initial begin
        dis = 1'b1; dir_tx = 1'b0; odd_sel = 1'b0; par_in = 1'b0;
        a_in = '0; b_in = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // start-up state: disabled, nothing driven (R3)
        chk("R3", W'({a_oe, b_oe, par_oe, ok_oe}), W'(0));

        for (int dv = 0; dv < 2; dv++)
        for (int dr = 0; dr < 2; dr++)
        for (int sl = 0; sl < 2; sl++)
        for (int pv = 0; pv < 2; pv++)
        for (int d = 0; d < 256; d++) begin
            dis     = dv[0];
            dir_tx  = dr[0];
            odd_sel = sl[0];
            par_in  = pv[0];
            a_in    = W'(d);
            b_in    = W'(d) ^ W'(8'h5A);
            @(posedge clk);
            @(negedge clk);
            if (dis) begin
                chk("R3", W'({a_oe, b_oe, par_oe, ok_oe}), W'(0));
            end else if (dir_tx) begin
                chk("R1", W'({a_oe, b_oe}), W'(2'b01));
                chk("R1", b_out, a_in);
                chk("R8", W'(ok_oe), W'(0));
                chk(odd_sel ? "R5" : "R4", W'(par_oe), W'(1));
                chk(odd_sel ? "R5" : "R4", W'(par_out),
                    W'((ones(a_in) % 2 == 1) ? !odd_sel : odd_sel));
            end else begin
                chk("R2", W'({a_oe, b_oe}), W'(2'b10));
                chk("R2", a_out, b_in);
                chk("R6", W'({par_oe, ok_oe}), W'(2'b01));
                chk(odd_sel ? "R7" : "R6", W'(ok_out),
                    W'(((ones(b_in) + int'(par_in)) % 2 == 0) ? !odd_sel : odd_sel));
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule